// File: doc/BRIEF.md
# Tagged Inter-Thread FIFO Cell

This block is one storage cell that threads use to pass 64-bit words to each other. It holds up to `DEPTH` entries in a circular buffer. A tag sits beside the buffer and keeps an empty flag, a full flag, a trap bit, a fill pointer and a constant FIFO-type marker. Every access arrives on a single port. The port carries a read strobe, a write strobe, a 4-bit view code, write data and a requester ID. The response comes back in the same cycle: read data, a `blocked` indication and a `wake` pulse.

The view code selects how the access is treated:

- **Raw view (0):** reaches the head entry or the newest entry directly.
- **Tag view (1):** reads the tag word, or writes the trap and flag bits.
- **Waiting handshake view (2):** pops on read and pushes on write, with empty/full handshake. An access it cannot complete is reported as blocked, and the requester is recorded in a 64-bit mask.
- **Non-waiting handshake view (3):** does the same pops and pushes but never blocks.

A later handshake access that completes raises `wake` and clears the mask. The block only reports blocking. It does not stall any thread or decode any address.

Top module: `xthread_cell`

## Requirements
- R1: After reset the tag reads as empty=1, full=0, trap=0, fill pointer 0, FIFO-type marker 1, depth code log2(DEPTH). Head position is 0.
- R2: A tag-view read (code 1) returns the depth code in bits 31:28, the fill pointer from bit 18 upward, the FIFO marker at bit 17, trap at bit 16, full at bit 1 and empty at bit 0. All other bits are zero.
- R3: A tag-view write loads trap from bit 16, full from bit 1 and empty from bit 0. When bit 0 is 1 it also zeroes the fill pointer. Stored entries and the head position are unchanged.
- R4: A handshake write (code 2 or 3) clears empty. If the pointer is below DEPTH it stores the word at slot (head+pointer) mod DEPTH and increments the pointer. Full is set when the pointer reaches DEPTH. Otherwise full keeps its value.
- R5: A handshake read clears full. If the pointer is non-zero it returns the head entry, advances the head modulo DEPTH and decrements the pointer. Empty is set once the pointer is zero.
- R6: A code-2 read while empty=1 asserts `blocked`, returns 0 and pops nothing. It sets the mask bit of `acc_rid`. It still clears full.
- R7: A code-2 write while full=1 asserts `blocked`, stores nothing and sets the mask bit of `acc_rid`. It still clears empty.
- R8: A code-3 read with pointer 0 returns 0 without blocking. A code-3 write with pointer DEPTH drops the word without blocking.
- R9: A handshake access that is not blocked pulses `wake` in its own cycle exactly when the mask is non-zero, and it clears the mask. `blocked` and `wake` are never high together.
- R10: A raw-view read returns the head entry without popping. A raw-view write overwrites slot (head+pointer-1) mod DEPTH when the pointer is non-zero. With pointer 0 it changes no entry.
- R11: Codes 4 and 5 read as 0. Codes 6 to 15 read as all ones. Writes in codes 4 to 15 change nothing.
- R12: When read and write strobes are both high, only the read takes place. With no read strobe `rd_data` is 0.
- R13: The fill pointer never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_view | input | 4 | View code |
| acc_wdata | input | 64 | Write data |
| acc_rid | input | 6 | Requester ID for the blocked mask |
| rd_data | output | 64 | Read data, valid in the access cycle |
| blocked | output | 1 | Access could not complete |
| wake | output | 1 | Recorded requesters should retry |

## Verification
A wrong head position or fill pointer becomes visible at the next tag-view read. It also shows when the following handshake pop returns a word that is out of sequence. A flag left stale first appears as a wrong `blocked` on the next waiting access to that cell. A lost mask bit shows up as a missing `wake` on the very next access that completes. The newest-slot arithmetic stays hidden until the slot is popped or wraps to the head. For that reason the bench wraps the buffer around before it reads the raw head.

// File: rtl/xtc_pkg.sv
package xtc_pkg;

  localparam logic [3:0] VIEW_RAW      = 4'd0;
  localparam logic [3:0] VIEW_TAG      = 4'd1;
  localparam logic [3:0] VIEW_HS_WAIT  = 4'd2;
  localparam logic [3:0] VIEW_HS_TRY   = 4'd3;
  localparam logic [3:0] VIEW_CNT_WAIT = 4'd4;
  localparam logic [3:0] VIEW_CNT_TRY  = 4'd5;

  localparam int TAG_DCODE_LSB = 28;
  localparam int TAG_PTR_LSB   = 18;
  localparam int TAG_FIFO_BIT  = 17;
  localparam int TAG_TRAP_BIT  = 16;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_EMPTY_BIT = 0;

  // Assemble the tag word seen through the tag view.
  function automatic logic [63:0] pack_tag(input logic [3:0] dcode,
                                           input logic [9:0] ptr,
                                           input logic       trap,
                                           input logic       full,
                                           input logic       empty);
    logic [63:0] w;
    w = '0;
    w[TAG_DCODE_LSB +: 4] = dcode;
    w[TAG_PTR_LSB +: 10]  = ptr;
    w[TAG_FIFO_BIT]       = 1'b1;
    w[TAG_TRAP_BIT]       = trap;
    w[TAG_FULL_BIT]       = full;
    w[TAG_EMPTY_BIT]      = empty;
    return w;
  endfunction

endpackage

// File: rtl/xtc_view_dec.sv
module xtc_view_dec
  import xtc_pkg::*;
(
  input  logic       rd,
  input  logic       wr,
  input  logic [3:0] view,
  output logic       raw_rd,
  output logic       raw_wr,
  output logic       tag_rd,
  output logic       tag_wr,
  output logic       hs_rd,
  output logic       hs_wr,
  output logic       hs_wait,
  output logic       cnt_rd,
  output logic       bad_rd
);
  logic wr_only;
  logic is_hs;

  assign wr_only = wr & ~rd;
  assign is_hs   = (view == VIEW_HS_WAIT) | (view == VIEW_HS_TRY);

  assign raw_rd  = rd & (view == VIEW_RAW);
  assign raw_wr  = wr_only & (view == VIEW_RAW);
  assign tag_rd  = rd & (view == VIEW_TAG);
  assign tag_wr  = wr_only & (view == VIEW_TAG);
  assign hs_rd   = rd & is_hs;
  assign hs_wr   = wr_only & is_hs;
  assign hs_wait = (view == VIEW_HS_WAIT);
  assign cnt_rd  = rd & ((view == VIEW_CNT_WAIT) | (view == VIEW_CNT_TRY));
  assign bad_rd  = rd & (view > VIEW_CNT_TRY);
endmodule

// File: rtl/xtc_store.sv
module xtc_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == IW'(g)) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[ridx];
endmodule

// File: rtl/xtc_tag_ctl.sv
module xtc_tag_ctl #(
  parameter int DEPTH = 8,
  parameter int NREQ  = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int RW   = $clog2(NREQ)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tag_wr,
  input  logic          hs_rd,
  input  logic          hs_wr,
  input  logic          hs_wait,
  input  logic          raw_wr,
  input  logic          wd_trap,
  input  logic          wd_full,
  input  logic          wd_empty,
  input  logic [RW-1:0] rid,
  output logic          empty_q,
  output logic          full_q,
  output logic          trap_q,
  output logic [PW-1:0] ptr_q,
  output logic [IW-1:0] head_q,
  output logic          mask_nz,
  output logic          stall,
  output logic          wake,
  output logic          pop,
  output logic          ram_we,
  output logic [IW-1:0] ram_widx
);
  logic [NREQ-1:0] mask_q;
  logic [NREQ-1:0] req_bit;
  logic            go;
  logic            push;
  logic [PW-1:0]   ptr_after;

  // Slot that lies ofs places after base, wrapping at DEPTH.
  function automatic logic [IW-1:0] slot_at(input logic [IW-1:0] base,
                                            input logic [PW-1:0] ofs);
    logic [PW-1:0] s;
    s = PW'(base) + ofs;
    return s[IW-1:0];
  endfunction

  assign req_bit   = NREQ'(1) << rid;
  assign mask_nz   = |mask_q;
  assign stall     = (hs_rd & hs_wait & empty_q) | (hs_wr & hs_wait & full_q);
  assign go        = (hs_rd | hs_wr) & ~stall;
  assign wake      = go & mask_nz;
  assign pop       = go & hs_rd & (ptr_q != '0);
  assign push      = go & hs_wr & (ptr_q < PW'(DEPTH));
  assign ptr_after = pop ? ptr_q - PW'(1) : (push ? ptr_q + PW'(1) : ptr_q);

  assign ram_we    = push | (raw_wr & (ptr_q != '0));
  assign ram_widx  = push ? slot_at(head_q, ptr_q) : slot_at(head_q, ptr_q - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      trap_q  <= 1'b0;
      ptr_q   <= '0;
      head_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (tag_wr) begin
        trap_q  <= wd_trap;
        full_q  <= wd_full;
        empty_q <= wd_empty;
        if (wd_empty) ptr_q <= '0;
      end
      if (hs_rd) begin
        full_q <= 1'b0;
        if (stall) begin
          mask_q <= mask_q | req_bit;
        end else begin
          mask_q <= '0;
          ptr_q  <= ptr_after;
          if (pop) head_q <= head_q + IW'(1);
          if (ptr_after == '0) empty_q <= 1'b1;
        end
      end
      if (hs_wr) begin
        empty_q <= 1'b0;
        if (stall) begin
          mask_q <= mask_q | req_bit;
        end else begin
          mask_q <= '0;
          ptr_q  <= ptr_after;
          if (ptr_after == PW'(DEPTH)) full_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xthread_cell.sv
module xthread_cell
  import xtc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NREQ  = 64,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int RW   = $clog2(NREQ),
  localparam logic [3:0] DCODE = 4'($clog2(DEPTH))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [3:0]    acc_view,
  input  logic [63:0]   acc_wdata,
  input  logic [RW-1:0] acc_rid,
  output logic [63:0]   rd_data,
  output logic          blocked,
  output logic          wake
);
  logic raw_rd, raw_wr, tag_rd, tag_wr, hs_rd, hs_wr, hs_wait, cnt_rd, bad_rd;
  logic flag_empty, flag_full, flag_trap, mask_nz, stall, pop, ram_we;
  logic [PW-1:0] fill_ptr;
  logic [IW-1:0] head_idx, ram_widx;
  logic [63:0]   head_word;

  xtc_view_dec u_dec (
    .rd(acc_rd), .wr(acc_wr), .view(acc_view),
    .raw_rd(raw_rd), .raw_wr(raw_wr), .tag_rd(tag_rd), .tag_wr(tag_wr),
    .hs_rd(hs_rd), .hs_wr(hs_wr), .hs_wait(hs_wait),
    .cnt_rd(cnt_rd), .bad_rd(bad_rd)
  );

  xtc_tag_ctl #(.DEPTH(DEPTH), .NREQ(NREQ)) u_tag (
    .clk(clk), .rst_n(rst_n),
    .tag_wr(tag_wr), .hs_rd(hs_rd), .hs_wr(hs_wr), .hs_wait(hs_wait),
    .raw_wr(raw_wr),
    .wd_trap(acc_wdata[TAG_TRAP_BIT]), .wd_full(acc_wdata[TAG_FULL_BIT]),
    .wd_empty(acc_wdata[TAG_EMPTY_BIT]), .rid(acc_rid),
    .empty_q(flag_empty), .full_q(flag_full), .trap_q(flag_trap),
    .ptr_q(fill_ptr), .head_q(head_idx), .mask_nz(mask_nz),
    .stall(stall), .wake(wake), .pop(pop),
    .ram_we(ram_we), .ram_widx(ram_widx)
  );

  xtc_store #(.DEPTH(DEPTH), .DW(64)) u_store (
    .clk(clk), .we(ram_we), .widx(ram_widx), .wdata(acc_wdata),
    .ridx(head_idx), .rdata(head_word)
  );

  assign blocked = stall;

  always_comb begin
    rd_data = '0;
    if (raw_rd)      rd_data = head_word;
    else if (tag_rd) rd_data = pack_tag(DCODE, 10'(fill_ptr), flag_trap, flag_full, flag_empty);
    else if (hs_rd)  rd_data = pop ? head_word : '0;
    else if (cnt_rd) rd_data = '0;
    else if (bad_rd) rd_data = '1;
  end
endmodule

// File: rtl/xthread_cell_chk.sv
module xthread_cell_chk #(
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_rd,
  input logic          acc_wr,
  input logic [3:0]    acc_view,
  input logic [63:0]   acc_wdata,
  input logic [63:0]   rd_data,
  input logic          blocked,
  input logic          wake,
  input logic [PW-1:0] fill_ptr,
  input logic          flag_full,
  input logic          flag_empty,
  input logic          mask_nz
);
  logic hs_view;
  assign hs_view = (acc_view == 4'd2) || (acc_view == 4'd3);

  assert_ptr_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ptr <= PW'(DEPTH));

  assert_no_wake_while_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !wake);

  assert_wake_clears_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !mask_nz);

  assert_hs_read_clears_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && hs_view) |=> !flag_full);

  assert_hs_write_clears_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_rd && hs_view) |=> !flag_empty);

  assert_tag_empty_zeroes_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !acc_rd && acc_view == 4'd1 && acc_wdata[0]) |=> (fill_ptr == '0));

  assert_bad_view_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && acc_view > 4'd5) |-> (rd_data == '1));

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |-> (rd_data == '0));

  assert_block_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> $stable(fill_ptr));
endmodule

bind xthread_cell xthread_cell_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
  .acc_view(acc_view), .acc_wdata(acc_wdata), .rd_data(rd_data),
  .blocked(blocked), .wake(wake), .fill_ptr(fill_ptr),
  .flag_full(flag_full), .flag_empty(flag_empty), .mask_nz(mask_nz)
);

// File: tb/xthread_cell_bench.sv
module xthread_cell_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_rd = 1'b0, acc_wr = 1'b0;
  logic [3:0]  acc_view = '0;
  logic [63:0] acc_wdata = '0;
  logic [5:0]  acc_rid = '0;
  logic [63:0] rd_data;
  logic        blocked, wake;

  int n_chk = 0;
  int n_bad = 0;

  logic [63:0] r_d;
  logic        r_b, r_w;

  always #2.5 clk = ~clk;

  xthread_cell u_xthread_cell (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_view(acc_view), .acc_wdata(acc_wdata), .acc_rid(acc_rid),
    .rd_data(rd_data), .blocked(blocked), .wake(wake)
  );

  function automatic logic [63:0] tagw(int ptr, bit t, bit f, bit e);
    logic [63:0] w;
    w = 64'h3 << 28;
    w = w | (64'(ptr) << 18) | (64'h1 << 17) | (64'(t) << 16) | (64'(f) << 1) | 64'(e);
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit rd, input bit wr, input logic [3:0] v,
                     input logic [63:0] d, input logic [5:0] rid);
    @(negedge clk);
    acc_rd = rd; acc_wr = wr; acc_view = v; acc_wdata = d; acc_rid = rid;
    #1;
    r_d = rd_data; r_b = blocked; r_w = wake;
    @(posedge clk);
    #1;
    acc_rd = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic t_reset;
    acc(1, 0, 4'd1, 0, 0);
    chk("R1 reset tag", r_d, tagw(0, 0, 0, 1));
    #1 chk("R12 idle data", rd_data, 64'h0);
  endtask

  task automatic t_fill;
    acc(0, 1, 4'd3, 64'h100, 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R2 tag after one push", r_d, tagw(1, 0, 0, 0));
    for (int i = 1; i < 8; i++) acc(0, 1, 4'd3, 64'h100 + 64'(i), 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R4 full after DEPTH pushes", r_d, tagw(8, 0, 1, 0));
  endtask

  task automatic t_full;
    acc(0, 1, 4'd3, 64'h999, 0);
    chk("R8 try write full no block", {63'd0, r_b}, 64'd0);
    acc(1, 0, 4'd0, 0, 0);
    chk("R10 raw head read", r_d, 64'h100);
    acc(0, 1, 4'd0, 64'hAAA, 0);
    acc(0, 1, 4'd2, 64'h777, 6'd5);
    chk("R7 waiting write on full blocks", {63'd0, r_b}, 64'd1);
    acc(1, 0, 4'd1, 0, 0);
    chk("R7 tag unchanged after block", r_d, tagw(8, 0, 1, 0));
  endtask

  task automatic t_drain;
    acc(1, 0, 4'd2, 0, 0);
    chk("R9 wake on first pop", {63'd0, r_w}, 64'd1);
    chk("R5 pop order 0", r_d, 64'h100);
    for (int i = 1; i < 7; i++) begin
      acc(1, 0, 4'd2, 0, 0);
      chk("R5 pop order", r_d, 64'h100 + 64'(i));
      chk("R9 no wake with empty mask", {63'd0, r_w}, 64'd0);
    end
    acc(1, 0, 4'd2, 0, 0);
    chk("R10 newest overwritten / R8 dropped", r_d, 64'hAAA);
    acc(1, 0, 4'd1, 0, 0);
    chk("R5 empty after drain", r_d, tagw(0, 0, 0, 1));
  endtask

  task automatic t_empty;
    acc(1, 0, 4'd3, 0, 0);
    chk("R8 try read empty data", r_d, 64'h0);
    chk("R8 try read empty no block", {63'd0, r_b}, 64'd0);
    acc(1, 0, 4'd2, 0, 6'd3);
    chk("R6 waiting read empty blocks", {63'd0, r_b}, 64'd1);
    chk("R6 blocked read data zero", r_d, 64'h0);
    chk("R9 not blocked and woken", {63'd0, r_w}, 64'd0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R6 tag unchanged", r_d, tagw(0, 0, 0, 1));
    acc(0, 1, 4'd3, 64'h55, 0);
    chk("R9 wake on write after blocked read", {63'd0, r_w}, 64'd1);
    acc(1, 0, 4'd3, 0, 0);
    chk("R5 pop after wake", r_d, 64'h55);
  endtask

  task automatic t_raw_zero;
    acc(0, 1, 4'd0, 64'hDEAD, 0);
    for (int i = 0; i < 7; i++) acc(0, 1, 4'd3, 64'h200 + 64'(i), 0);
    for (int i = 0; i < 7; i++) acc(1, 0, 4'd3, 0, 0);
    acc(1, 0, 4'd0, 0, 0);
    chk("R10 raw write with ptr zero ignored", r_d, 64'h55);
  endtask

  task automatic t_tag;
    acc(0, 1, 4'd3, 64'h31, 0);
    acc(0, 1, 4'd3, 64'h32, 0);
    acc(0, 1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R3 tag write sets trap/full", r_d, tagw(2, 1, 1, 0));
    acc(0, 1, 4'd2, 64'h888, 6'd7);
    chk("R7 waiting write on forced full", {63'd0, r_b}, 64'd1);
    acc(0, 1, 4'd3, 64'h33, 0);
    chk("R9 wake on try write", {63'd0, r_w}, 64'd1);
    acc(1, 0, 4'd1, 0, 0);
    chk("R4 full kept below DEPTH", r_d, tagw(3, 1, 1, 0));
    acc(1, 0, 4'd3, 0, 0);
    chk("R5 pop head", r_d, 64'h31);
    acc(0, 1, 4'd1, 64'h1, 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R3 empty write zeroes ptr", r_d, tagw(0, 0, 0, 1));
    acc(1, 0, 4'd0, 0, 0);
    chk("R3 head kept", r_d, 64'h32);
  endtask

  task automatic t_views;
    acc(1, 0, 4'd4, 0, 0);
    chk("R11 code 4 reads zero", r_d, 64'h0);
    acc(1, 0, 4'd5, 0, 0);
    chk("R11 code 5 reads zero", r_d, 64'h0);
    acc(1, 0, 4'd9, 0, 0);
    chk("R11 code 9 reads ones", r_d, '1);
    acc(1, 0, 4'd15, 0, 0);
    chk("R11 code 15 reads ones", r_d, '1);
    acc(0, 1, 4'd4, 64'h3, 0);
    acc(0, 1, 4'd5, 64'h3, 0);
    acc(0, 1, 4'd9, 64'h3, 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R11 writes ignored tag", r_d, tagw(0, 0, 0, 1));
    acc(1, 0, 4'd0, 0, 0);
    chk("R11 writes ignored head", r_d, 64'h32);
  endtask

  task automatic t_both;
    acc(0, 1, 4'd3, 64'h44, 0);
    acc(1, 1, 4'd0, 64'h99, 0);
    chk("R12 read wins", r_d, 64'h44);
    acc(1, 0, 4'd0, 0, 0);
    chk("R12 write dropped", r_d, 64'h44);
    acc(1, 1, 4'd3, 64'h66, 0);
    acc(1, 0, 4'd1, 0, 0);
    chk("R12 only pop on both", r_d, tagw(0, 0, 0, 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_fill();
    t_full();
    t_drain();
    t_empty();
    t_raw_zero();
    t_tag();
    t_views();
    t_both();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule